// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block is the purely combinational hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the instruction class held in the decode, execute, memory and write-back pipeline registers. It also looks at the source registers of the decode instruction, the load destination of the execute instruction and the branch condition outcome. From these it decides, every cycle, which pipeline registers hold their value and which ones are replaced with a nop.

Three hazard policies are handled, and each has a fixed cycle cost:

- **Load-use.** A dependent instruction right behind a load waits one cycle in decode.
- **Misprediction.** Conditional jumps are predicted taken. When the prediction is wrong, the two younger instructions are squashed before either can reach execute.
- **Return.** A return blocks fetch until its target is read out of memory.

A fetched halt freezes the fetch address. The block also drives the select for the next fetch address: the predicted address, the fall-through address of a mispredicted jump now in memory, or the return address now in write-back.

Top module: `hz_ctrl`

## Requirements

- R1: Class codes are NOP=0, HALT=1, ALU=2, STORE=3, LOAD=4, JCC=5, CALL=6, RET=7, PUSH=8, POP=9. A LOAD or POP in execute whose memory destination equals decode source A or source B causes the following outputs: `stall_f_o`=1, `stall_d_o`=1, `bubble_e_o`=1, `bubble_d_o`=0. In a program this costs exactly one extra cycle.
- R2: Register id 4'hF means "none". In the following cases no load-use hazard is raised: the destination is none, no source matches, or the execute instruction is not LOAD or POP.
- R3: A JCC in execute with its condition false is a misprediction. It gives `bubble_d_o`=1, `bubble_e_o`=1, `stall_f_o`=0 and `stall_d_o`=0, and costs exactly two extra cycles.
- R4: A jump whose condition is true (predicted taken correctly) costs no extra cycles.
- R5: While a RET is in decode, execute or memory, `stall_f_o`=1 and `bubble_d_o`=1. Each RET costs exactly three extra cycles.
- R6: `pc_sel_o` takes one of three values:
  - 1 when a JCC with a false condition is in memory;
  - otherwise 2 when a RET is in write-back;
  - otherwise 0.
- R7: A HALT in decode, execute or memory sets `stall_f_o`=1 without any bubble, unless a misprediction is present.
- R8: Priority order applies:
  - A misprediction overrides load-use, return and halt. The result is a squash with fetch free.
  - A load-use hazard with a RET in decode holds the RET (`stall_d_o`=1, `bubble_d_o`=0).
- R9: A program retires its halt after one cycle per executed instruction plus 4, plus the penalties above. A lone halt takes 5 cycles.
- R10: `stall_d_o` and `bubble_d_o` are never both 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| d_cls_i | input | 4 | class of instruction in decode |
| d_src_a_i | input | 4 | decode source A register id |
| d_src_b_i | input | 4 | decode source B register id |
| e_cls_i | input | 4 | class of instruction in execute |
| e_cnd_i | input | 1 | condition outcome computed in execute |
| e_dst_m_i | input | 4 | memory-loaded destination of execute instruction |
| m_cls_i | input | 4 | class of instruction in memory |
| m_cnd_i | input | 1 | condition outcome carried into memory |
| w_cls_i | input | 4 | class of instruction in write-back |
| stall_f_o | output | 1 | hold predicted fetch address |
| stall_d_o | output | 1 | hold decode register |
| bubble_d_o | output | 1 | load nop into decode register |
| bubble_e_o | output | 1 | load nop into execute register |
| pc_sel_o | output | 2 | next fetch address select (0 pred, 1 fall-through, 2 return) |

## Verification

The bench runs short programs through a cycle model of the pipeline and compares the cycle at which the halt retires against the cost rules. A controller that squashed at the wrong stage, or that stalled instead of bubbling, would therefore shift the count by one or more cycles.

Port-level cases go after collisions that rarely line up in a program:

- A wrong-path return or halt sitting in decode while a misprediction fires. A design that let the return block fetch would wrongly hold the fetch address.
- A pop that feeds a return's stack pointer. A design that bubbled the return instead of holding it would lose the return.
- A "none" destination matching a "none" source. A careless comparator would stall on this for nothing.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int CLS_W = 4;
  localparam int REG_W = 4;
  localparam int SEL_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP   = 4'd0,
    CLS_HALT  = 4'd1,
    CLS_ALU   = 4'd2,
    CLS_STORE = 4'd3,
    CLS_LOAD  = 4'd4,
    CLS_JCC   = 4'd5,
    CLS_CALL  = 4'd6,
    CLS_RET   = 4'd7,
    CLS_PUSH  = 4'd8,
    CLS_POP   = 4'd9
  } cls_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_PRED = 2'd0,
    SEL_FALL = 2'd1,
    SEL_RET  = 2'd2
  } pc_sel_e;
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W = 4,
  parameter int CLS_W = 4,
  parameter int NSRC  = 2
) (
  input  logic [CLS_W-1:0]            e_cls_i,
  input  logic [REG_W-1:0]            e_dst_m_i,
  input  logic [NSRC-1:0][REG_W-1:0]  d_src_i,
  output logic                        hit_o
);
  localparam logic [REG_W-1:0] REG_NONE = '1;

  logic            is_load;
  logic [NSRC-1:0] match;

  assign is_load = (e_cls_i == hz_pkg::CLS_LOAD) || (e_cls_i == hz_pkg::CLS_POP);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign match[g] = (d_src_i[g] == e_dst_m_i);
  end

  assign hit_o = is_load && (e_dst_m_i != REG_NONE) && (|match);
endmodule

// File: rtl/hz_flow.sv
module hz_flow #(
  parameter int CLS_W = 4,
  parameter int SEL_W = 2
) (
  input  logic [CLS_W-1:0] d_cls_i,
  input  logic [CLS_W-1:0] e_cls_i,
  input  logic             e_cnd_i,
  input  logic [CLS_W-1:0] m_cls_i,
  input  logic             m_cnd_i,
  input  logic [CLS_W-1:0] w_cls_i,
  output logic             mispred_o,
  output logic             ret_busy_o,
  output logic             halt_busy_o,
  output logic [SEL_W-1:0] pc_sel_o
);
  import hz_pkg::*;

  logic fix_fetch;

  assign mispred_o   = (e_cls_i == CLS_JCC) && !e_cnd_i;
  assign fix_fetch   = (m_cls_i == CLS_JCC) && !m_cnd_i;
  assign ret_busy_o  = (d_cls_i == CLS_RET) || (e_cls_i == CLS_RET) || (m_cls_i == CLS_RET);
  assign halt_busy_o = (d_cls_i == CLS_HALT) || (e_cls_i == CLS_HALT) || (m_cls_i == CLS_HALT);

  always_comb begin
    pc_sel_o = SEL_PRED;
    if (fix_fetch)                pc_sel_o = SEL_FALL;
    else if (w_cls_i == CLS_RET)  pc_sel_o = SEL_RET;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int CLS_W = hz_pkg::CLS_W,
  parameter int REG_W = hz_pkg::REG_W,
  parameter int SEL_W = hz_pkg::SEL_W
) (
  input  logic [CLS_W-1:0] d_cls_i,
  input  logic [REG_W-1:0] d_src_a_i,
  input  logic [REG_W-1:0] d_src_b_i,
  input  logic [CLS_W-1:0] e_cls_i,
  input  logic             e_cnd_i,
  input  logic [REG_W-1:0] e_dst_m_i,
  input  logic [CLS_W-1:0] m_cls_i,
  input  logic             m_cnd_i,
  input  logic [CLS_W-1:0] w_cls_i,
  output logic             stall_f_o,
  output logic             stall_d_o,
  output logic             bubble_d_o,
  output logic             bubble_e_o,
  output logic [SEL_W-1:0] pc_sel_o
);
  localparam int NSRC = 2;

  logic load_use, mispred, ret_busy, halt_busy;

  hz_load_use #(.REG_W(REG_W), .CLS_W(CLS_W), .NSRC(NSRC)) u_lu (
    .e_cls_i   (e_cls_i),
    .e_dst_m_i (e_dst_m_i),
    .d_src_i   ({d_src_b_i, d_src_a_i}),
    .hit_o     (load_use)
  );

  hz_flow #(.CLS_W(CLS_W), .SEL_W(SEL_W)) u_flow (
    .d_cls_i     (d_cls_i),
    .e_cls_i     (e_cls_i),
    .e_cnd_i     (e_cnd_i),
    .m_cls_i     (m_cls_i),
    .m_cnd_i     (m_cnd_i),
    .w_cls_i     (w_cls_i),
    .mispred_o   (mispred),
    .ret_busy_o  (ret_busy),
    .halt_busy_o (halt_busy),
    .pc_sel_o    (pc_sel_o)
  );

  // priority: squash > load-use hold > return/halt freeze
  always_comb begin
    stall_f_o  = 1'b0;
    stall_d_o  = 1'b0;
    bubble_d_o = 1'b0;
    bubble_e_o = 1'b0;
    if (mispred) begin
      bubble_d_o = 1'b1;
      bubble_e_o = 1'b1;
    end else if (load_use) begin
      stall_f_o  = 1'b1;
      stall_d_o  = 1'b1;
      bubble_e_o = 1'b1;
    end else if (ret_busy) begin
      stall_f_o  = 1'b1;
      bubble_d_o = 1'b1;
    end else if (halt_busy) begin
      stall_f_o  = 1'b1;
    end
  end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk (
  input logic [3:0] d_cls_i,
  input logic [3:0] d_src_a_i,
  input logic [3:0] d_src_b_i,
  input logic [3:0] e_cls_i,
  input logic       e_cnd_i,
  input logic [3:0] e_dst_m_i,
  input logic [3:0] m_cls_i,
  input logic       m_cnd_i,
  input logic [3:0] w_cls_i,
  input logic       stall_f_o,
  input logic       stall_d_o,
  input logic       bubble_d_o,
  input logic       bubble_e_o,
  input logic [1:0] pc_sel_o
);
  import hz_pkg::*;

  logic e_jcc_bad, m_jcc_bad, ret_in, e_ld_dep;
  assign e_jcc_bad = (e_cls_i == CLS_JCC) && !e_cnd_i;
  assign m_jcc_bad = (m_cls_i == CLS_JCC) && !m_cnd_i;
  assign ret_in    = (d_cls_i == CLS_RET) || (e_cls_i == CLS_RET) || (m_cls_i == CLS_RET);
  assign e_ld_dep  = ((e_cls_i == CLS_LOAD) || (e_cls_i == CLS_POP)) && (e_dst_m_i != 4'hF) &&
                     ((e_dst_m_i == d_src_a_i) || (e_dst_m_i == d_src_b_i));

  always_comb begin
    p_hold_not_bubble_r10: assert (!(stall_d_o && bubble_d_o));
    if (e_jcc_bad)
      p_squash_free_fetch_r3: assert (bubble_d_o && bubble_e_o && !stall_f_o && !stall_d_o);
    if (e_ld_dep && !e_jcc_bad)
      p_load_use_hold_r1: assert (stall_d_o && stall_f_o && bubble_e_o);
    if (stall_d_o)
      p_hold_implies_exec_bubble_r1: assert (bubble_e_o);
    if (ret_in && !e_jcc_bad)
      p_ret_blocks_fetch_r5: assert (stall_f_o);
    if (m_jcc_bad)
      p_fall_through_sel_r6: assert (pc_sel_o == 2'd1);
    else if (w_cls_i == CLS_RET)
      p_ret_target_sel_r6: assert (pc_sel_o == 2'd2);
    if (d_cls_i == CLS_HALT && !e_jcc_bad)
      p_halt_freeze_r7: assert (stall_f_o);
  end
endmodule

bind hz_ctrl hz_ctrl_chk u_chk (
  .d_cls_i    (d_cls_i),
  .d_src_a_i  (d_src_a_i),
  .d_src_b_i  (d_src_b_i),
  .e_cls_i    (e_cls_i),
  .e_cnd_i    (e_cnd_i),
  .e_dst_m_i  (e_dst_m_i),
  .m_cls_i    (m_cls_i),
  .m_cnd_i    (m_cnd_i),
  .w_cls_i    (w_cls_i),
  .stall_f_o  (stall_f_o),
  .stall_d_o  (stall_d_o),
  .bubble_d_o (bubble_d_o),
  .bubble_e_o (bubble_e_o),
  .pc_sel_o   (pc_sel_o)
);

// File: tb/sim_hz_ctrl.sv
`timescale 1ns/1ps
module sim_hz_ctrl;
  import hz_pkg::*;

  typedef struct packed {
    logic [3:0] cls;
    logic [3:0] sa;
    logic [3:0] sb;
    logic [3:0] dm;
    logic       tk;
    logic [3:0] tgt;
    logic [3:0] valp;
  } ins_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  ins_t prog [16];
  ins_t sd, se, sm, sw;
  logic [3:0] fpc;

  logic       stall_f, stall_d, bubble_d, bubble_e;
  logic [1:0] pc_sel;

  hz_ctrl u0 (
    .d_cls_i    (sd.cls),
    .d_src_a_i  (sd.sa),
    .d_src_b_i  (sd.sb),
    .e_cls_i    (se.cls),
    .e_cnd_i    (se.tk),
    .e_dst_m_i  (se.dm),
    .m_cls_i    (sm.cls),
    .m_cnd_i    (sm.tk),
    .w_cls_i    (sw.cls),
    .stall_f_o  (stall_f),
    .stall_d_o  (stall_d),
    .bubble_d_o (bubble_d),
    .bubble_e_o (bubble_e),
    .pc_sel_o   (pc_sel)
  );

  function automatic ins_t mk(cls_e c, logic [3:0] a, logic [3:0] b, logic [3:0] d,
                              logic t, logic [3:0] g);
    ins_t r;
    r.cls = c; r.sa = a; r.sb = b; r.dm = d; r.tk = t; r.tgt = g; r.valp = 4'd0;
    return r;
  endfunction

  function automatic ins_t nop_i();
    return mk(CLS_NOP, 4'hF, 4'hF, 4'hF, 1'b0, 4'd0);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = mk(CLS_HALT, 4'hF, 4'hF, 4'hF, 1'b0, 4'd0);
  endtask

  task automatic idle_state();
    sd = nop_i(); se = nop_i(); sm = nop_i(); sw = nop_i();
  endtask

  // cycle model: cycle 1 fetches address 0; returns cycle in which halt sits in write-back
  task automatic run_prog(input string req, input int exp_cyc);
    int cyc;
    logic [3:0] pcx, npred;
    ins_t fi, ne;
    logic sf, sdl, bd, be;
    @(negedge clk);
    idle_state(); fpc = 4'd0; cyc = 1;
    #1;
    while (sw.cls != CLS_HALT && cyc < 64) begin
      sf = stall_f; sdl = stall_d; bd = bubble_d; be = bubble_e;
      pcx = (pc_sel == 2'd1) ? sm.valp : (pc_sel == 2'd2) ? sw.tgt : fpc;
      fi = prog[pcx];
      fi.valp = pcx + 4'd1;
      if (fi.cls == CLS_JCC || fi.cls == CLS_CALL) npred = fi.tgt;
      else if (fi.cls == CLS_HALT)                 npred = pcx;
      else                                         npred = pcx + 4'd1;
      @(negedge clk);
      ne = be ? nop_i() : sd;
      sw = sm; sm = se; se = ne;
      sd = bd ? nop_i() : (sdl ? sd : fi);
      if (!sf) fpc = npred;
      cyc++;
      #1;
    end
    check(cyc == exp_cyc, req, cyc, exp_cyc);
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp_v, input logic [1:0] exp_sel);
    #1;
    check({stall_f, stall_d, bubble_d, bubble_e} == exp_v, req,
          int'({stall_f, stall_d, bubble_d, bubble_e}), int'(exp_v));
    check(pc_sel == exp_sel, req, int'(pc_sel), int'(exp_sel));
  endtask

  task automatic t_idle();
    @(negedge clk); idle_state();
    expect_out("idle", 4'b0000, 2'd0);
  endtask

  task automatic t_lone_halt();
    clear_prog();
    run_prog("R9 lone halt", 5);
  endtask

  task automatic t_straight();
    clear_prog();
    prog[0] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    prog[1] = mk(CLS_ALU, 4'h2, 4'h3, 4'hF, 1'b0, 0);
    prog[2] = mk(CLS_STORE, 4'h1, 4'h3, 4'hF, 1'b0, 0);
    run_prog("R9 straight line", 8);
  endtask

  task automatic t_load_use();
    clear_prog();
    prog[0] = mk(CLS_LOAD, 4'hF, 4'h4, 4'h1, 1'b0, 0);
    prog[1] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R1 load-use srcA", 8);
    clear_prog();
    prog[0] = mk(CLS_POP, 4'h4, 4'h4, 4'h3, 1'b0, 0);
    prog[1] = mk(CLS_ALU, 4'hF, 4'h3, 4'hF, 1'b0, 0);
    run_prog("R1 pop-use srcB", 8);
    clear_prog();
    prog[0] = mk(CLS_LOAD, 4'hF, 4'h4, 4'h1, 1'b0, 0);
    prog[1] = mk(CLS_ALU, 4'h2, 4'h5, 4'hF, 1'b0, 0);
    run_prog("R2 load no dependency", 7);
  endtask

  task automatic t_jumps();
    clear_prog();
    prog[0] = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b0, 4'd3);
    prog[3] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    prog[4] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R3 mispredict", 8);
    clear_prog();
    prog[0] = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b1, 4'd2);
    prog[2] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R4 taken jump", 7);
    clear_prog();
    prog[0] = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b0, 4'd2);
    prog[2] = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 4'd5);
    prog[3] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R8 wrong-path ret", 8);
  endtask

  task automatic t_ret();
    clear_prog();
    prog[0] = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 4'd2);
    prog[1] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R5 ret", 9);
    clear_prog();
    prog[0] = mk(CLS_POP, 4'h4, 4'h4, 4'h4, 1'b0, 0);
    prog[1] = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 4'd3);
    prog[2] = mk(CLS_ALU, 4'h1, 4'h2, 4'hF, 1'b0, 0);
    run_prog("R8 pop then ret", 11);
  endtask

  task automatic t_ports();
    @(negedge clk); idle_state();
    se = mk(CLS_LOAD, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    sd = mk(CLS_ALU, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R2 none dst", 4'b0000, 2'd0);
    @(negedge clk);
    se = mk(CLS_ALU, 4'hF, 4'hF, 4'h2, 1'b0, 0);
    sd = mk(CLS_ALU, 4'h2, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R2 non-load", 4'b0000, 2'd0);
    @(negedge clk);
    se = mk(CLS_LOAD, 4'hF, 4'hF, 4'h6, 1'b0, 0);
    sd = mk(CLS_STORE, 4'h1, 4'h6, 4'hF, 1'b0, 0);
    expect_out("R1 hold decode", 4'b1101, 2'd0);
    @(negedge clk); idle_state();
    se = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    sd = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 0);
    expect_out("R8 squash beats ret", 4'b0011, 2'd0);
    @(negedge clk);
    sd = mk(CLS_HALT, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R8 squash beats halt", 4'b0011, 2'd0);
    @(negedge clk); idle_state();
    sd = mk(CLS_HALT, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R7 halt freeze", 4'b1000, 2'd0);
    @(negedge clk); idle_state();
    se = mk(CLS_POP, 4'h4, 4'h4, 4'h4, 1'b0, 0);
    sd = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 0);
    expect_out("R8 R10 load-use holds ret", 4'b1101, 2'd0);
    @(negedge clk); idle_state();
    sm = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R6 fall-through", 4'b0000, 2'd1);
    @(negedge clk); idle_state();
    sw = mk(CLS_RET, 4'hF, 4'hF, 4'hF, 1'b0, 0);
    expect_out("R6 return target", 4'b0000, 2'd2);
    @(negedge clk); idle_state();
    sm = mk(CLS_JCC, 4'hF, 4'hF, 4'hF, 1'b1, 0);
    expect_out("R6 R4 correct jump", 4'b0000, 2'd0);
    @(negedge clk); idle_state();
    sm = mk(CLS_RET, 4'h4, 4'h4, 4'hF, 1'b0, 0);
    expect_out("R5 ret in memory", 4'b1010, 2'd0);
  endtask

  initial begin
    idle_state(); fpc = 4'd0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_lone_halt();
    t_straight();
    t_load_use();
    t_jumps();
    t_ret();
    t_ports();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule